// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block counts how often a monitored event happens on one core. Each cycle it receives a small count of the event's occurrences on its own thread, the same count from a sibling hardware thread, and the current privilege level. A threshold test turns the occurrence count into a yes/no condition for the cycle. That condition can be inverted, reduced to its rising edges, and filtered by privilege level before it is accumulated into a 48-bit counter. With a zero threshold, the raw occurrence count is added each cycle instead.

Software controls the block through a packed configuration word. It can preset and read the counter and clear a sticky overflow flag. A separate 64-bit auxiliary qualifier register sits alongside the counter. It is written and read back independently and holds the extra qualifier word that one special event needs. All state sits behind register-style write strobes. A write lands on the clock edge and governs counting from the next cycle on.

Top module: `evt_filter_counter`

## Requirements
- R1: Configuration word layout: bit 0 run, bit 1 user enable, bit 2 kernel enable, bit 3 invert, bit 4 edge detect, bit 5 any-thread, bits 13:6 threshold. A write is visible on the readback port after the edge and governs counting from the following cycle. Reset clears the configuration, counter, overflow flag and auxiliary register to zero.
- R2: With threshold zero, each qualified cycle adds the raw occurrence count. Invert has no effect in this mode.
- R3: With a nonzero threshold and edge detect off, each qualified cycle adds one when the occurrence count is greater than or equal to the threshold, and zero otherwise.
- R4: With a nonzero threshold, invert makes the counter add one in the cycles where the count is below the threshold.
- R5: With a nonzero threshold and edge detect on, the counter adds one only in a cycle where the (possibly inverted) condition holds and did not hold in the previous cycle. While run is clear, the history is held at "not holding".
- R6: The invalid output is high exactly while the configuration has edge detect set and threshold zero. Counting then follows R2.
- R7: At privilege levels 1, 2 and 3, counting happens only if the user enable is set.
- R8: At privilege level 0, counting happens only if the kernel enable is set.
- R9: With any-thread set, the sibling's count is added to the own count before the threshold test. With it clear, the sibling input has no effect.
- R10: The counter is 48 bits wide and wraps modulo 2^48. A wrap sets a sticky overflow flag, which stays set until a clear strobe. A wrap in the same cycle as a clear wins.
- R11: A counter write loads the written value on the edge and takes priority over that cycle's increment.
- R12: The auxiliary 64-bit register loads on its own write strobe and reads back unchanged. It never touches the counter or the configuration.
- R13: With run clear and no counter write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_cnt_i | input | OCC_W | Occurrences of the event this cycle, own thread |
| sib_cnt_i | input | OCC_W | Occurrences of the event this cycle, sibling thread |
| priv_i | input | 2 | Current privilege level (0 = most privileged) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 14 | Configuration word to write |
| cfg_rdata_o | output | 14 | Active configuration word |
| cfg_invalid_o | output | 1 | Edge detect with zero threshold |
| cnt_we_i | input | 1 | Counter preset strobe |
| cnt_wdata_i | input | CNT_W | Counter preset value |
| cnt_rdata_o | output | CNT_W | Counter value |
| ovf_clr_i | input | 1 | Clear the sticky overflow flag |
| ovf_o | output | 1 | Sticky overflow flag |
| aux_we_i | input | 1 | Auxiliary register write strobe |
| aux_wdata_i | input | AUX_W | Auxiliary value to write |
| aux_rdata_o | output | AUX_W | Auxiliary register value |

## Verification
A bad edge-detect history bit or a stale configuration register shows up at the counter port one edge after the affected cycle, as an extra or missing count. A bad edge-detect history bit typically shows up the first time the condition rises after an enable. A corrupted accumulator or overflow flag is visible on the very next read, and it persists because both are sticky or accumulating. The bench compares every port after every edge against a cycle-level reference model, so any divergence is caught in the cycle it first appears.

// File: rtl/efc_pkg.sv
package efc_pkg;
   localparam int THR_W = 8;

   typedef struct packed {
      logic [THR_W-1:0] thr;
      logic             any_thr;
      logic             edge_on;
      logic             inv;
      logic             krn_en;
      logic             usr_en;
      logic             run;
   } efc_cfg_t;

   localparam int CFG_W = $bits(efc_cfg_t);
endpackage

// File: rtl/efc_cfg_regs.sv
module efc_cfg_regs
   import efc_pkg::*;
#(
   parameter int AUX_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  efc_cfg_t         cfg_wdata,
   output efc_cfg_t         cfg_q,
   input  logic             aux_we,
   input  logic [AUX_W-1:0] aux_wdata,
   output logic [AUX_W-1:0] aux_q,
   output logic             invalid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_we) begin
         cfg_q <= cfg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_q <= '0;
      end else if (aux_we) begin
         aux_q <= aux_wdata;
      end
   end

   always_comb begin
      invalid = cfg_q.edge_on && (cfg_q.thr == '0);
   end

   assert_cfg_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (cfg_q == $past(cfg_wdata)));
   assert_aux_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      aux_we |=> (aux_q == $past(aux_wdata)));
   assert_aux_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !aux_we |=> $stable(aux_q));
endmodule

// File: rtl/efc_qualifier.sv
module efc_qualifier
   import efc_pkg::*;
#(
   parameter int OCC_W         = 4,
   parameter bit ANY_THREAD_EN = 1'b1,
   localparam int DW           = OCC_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  efc_cfg_t         cfg,
   input  logic [OCC_W-1:0] evt_cnt,
   input  logic [OCC_W-1:0] sib_cnt,
   input  logic [1:0]       priv,
   output logic [DW-1:0]    delta
);
   localparam int CW = (DW > THR_W) ? DW : THR_W;

   logic [DW-1:0] occ_sum;
   logic          thr_zero;
   logic          cond;
   logic          hist_q;
   logic          priv_ok;
   logic [DW-1:0] raw_inc;

   generate
      if (ANY_THREAD_EN) begin : g_any
         always_comb begin
            occ_sum = cfg.any_thr ? (DW'(evt_cnt) + DW'(sib_cnt)) : DW'(evt_cnt);
         end
      end else begin : g_own
         always_comb begin
            occ_sum = DW'(evt_cnt);
         end
      end
   endgenerate

   always_comb begin
      thr_zero = (cfg.thr == '0);
      cond     = (CW'(occ_sum) >= CW'(cfg.thr)) ^ cfg.inv;
      priv_ok  = (priv == 2'd0) ? cfg.krn_en : cfg.usr_en;
      if (thr_zero) begin
         raw_inc = occ_sum;
      end else if (cfg.edge_on) begin
         raw_inc = DW'(cond && !hist_q);
      end else begin
         raw_inc = DW'(cond);
      end
      delta = priv_ok ? raw_inc : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= 1'b0;
      end else begin
         hist_q <= cfg.run ? cond : 1'b0;
      end
   end

   assert_thr_unit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.thr != '0) |-> (delta <= DW'(1)));
   assert_edge_norepeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.edge_on && cfg.thr != '0 && $past(cfg.run) && cfg.run && $stable(cfg)
       && $past(delta) != '0) |-> (delta == '0));
   assert_user_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (priv != 2'd0 && !cfg.usr_en) |-> (delta == '0));
   assert_kernel_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (priv == 2'd0 && !cfg.krn_en) |-> (delta == '0));
endmodule

// File: rtl/efc_accum.sv
module efc_accum #(
   parameter int CNT_W = 48,
   parameter int DW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DW-1:0]    delta,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_q
);
   logic [CNT_W:0] sum_ext;
   logic           wrap;

   always_comb begin
      sum_ext = {1'b0, cnt_q} + (CNT_W+1)'(delta);
      wrap    = run && !cnt_we && sum_ext[CNT_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_we) begin
         cnt_q <= cnt_wdata;
      end else if (run) begin
         cnt_q <= sum_ext[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (wrap) begin
         ovf_q <= 1'b1;
      end else if (ovf_clr) begin
         ovf_q <= 1'b0;
      end
   end

   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr) |=> ovf_q);
   assert_preset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> (cnt_q == $past(cnt_wdata)));
   assert_hold_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_we) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_filter_counter.sv
module evt_filter_counter
   import efc_pkg::*;
#(
   parameter int OCC_W         = 4,
   parameter int CNT_W         = 48,
   parameter int AUX_W         = 64,
   parameter bit ANY_THREAD_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [OCC_W-1:0]     evt_cnt_i,
   input  logic [OCC_W-1:0]     sib_cnt_i,
   input  logic [1:0]           priv_i,
   input  logic                 cfg_we_i,
   input  logic [CFG_W-1:0]     cfg_wdata_i,
   output logic [CFG_W-1:0]     cfg_rdata_o,
   output logic                 cfg_invalid_o,
   input  logic                 cnt_we_i,
   input  logic [CNT_W-1:0]     cnt_wdata_i,
   output logic [CNT_W-1:0]     cnt_rdata_o,
   input  logic                 ovf_clr_i,
   output logic                 ovf_o,
   input  logic                 aux_we_i,
   input  logic [AUX_W-1:0]     aux_wdata_i,
   output logic [AUX_W-1:0]     aux_rdata_o
);
   localparam int DW = OCC_W + 1;

   generate
      if (OCC_W < 1 || OCC_W > 7) begin : g_bad_occ
         $error("OCC_W must lie in 1..7");
      end
      if (CNT_W <= DW || CNT_W > 64) begin : g_bad_cnt
         $error("CNT_W must exceed OCC_W+1 and not exceed 64");
      end
      if (AUX_W < 1) begin : g_bad_aux
         $error("AUX_W must be positive");
      end
   endgenerate

   efc_cfg_t      cfg_q;
   logic [DW-1:0] delta;

   efc_cfg_regs #(.AUX_W(AUX_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we_i),
      .cfg_wdata (efc_cfg_t'(cfg_wdata_i)),
      .cfg_q     (cfg_q),
      .aux_we    (aux_we_i),
      .aux_wdata (aux_wdata_i),
      .aux_q     (aux_rdata_o),
      .invalid   (cfg_invalid_o)
   );

   efc_qualifier #(.OCC_W(OCC_W), .ANY_THREAD_EN(ANY_THREAD_EN)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (cfg_q),
      .evt_cnt (evt_cnt_i),
      .sib_cnt (sib_cnt_i),
      .priv    (priv_i),
      .delta   (delta)
   );

   efc_accum #(.CNT_W(CNT_W), .DW(DW)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (cfg_q.run),
      .delta     (delta),
      .cnt_we    (cnt_we_i),
      .cnt_wdata (cnt_wdata_i),
      .ovf_clr   (ovf_clr_i),
      .cnt_q     (cnt_rdata_o),
      .ovf_q     (ovf_o)
   );

   always_comb begin
      cfg_rdata_o = cfg_q;
   end

   assert_invalid_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_invalid_o |-> (cfg_q.edge_on && cfg_q.thr == '0));
endmodule

// File: tb/evt_filter_counter_bench.sv
`timescale 1ns/1ps
module evt_filter_counter_bench;
   import efc_pkg::*;

   localparam int OCC_W = 4;
   localparam int CNT_W = 48;
   localparam int AUX_W = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [OCC_W-1:0] evt_cnt_i = '0, sib_cnt_i = '0;
   logic [1:0]       priv_i = '0;
   logic             cfg_we_i = 1'b0, cnt_we_i = 1'b0, ovf_clr_i = 1'b0, aux_we_i = 1'b0;
   logic [CFG_W-1:0] cfg_wdata_i = '0, cfg_rdata_o;
   logic             cfg_invalid_o, ovf_o;
   logic [CNT_W-1:0] cnt_wdata_i = '0, cnt_rdata_o;
   logic [AUX_W-1:0] aux_wdata_i = '0, aux_rdata_o;

   evt_filter_counter u_evt_filter_counter (
      .clk(clk), .rst_n(rst_n), .evt_cnt_i(evt_cnt_i), .sib_cnt_i(sib_cnt_i),
      .priv_i(priv_i), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
      .cfg_rdata_o(cfg_rdata_o), .cfg_invalid_o(cfg_invalid_o),
      .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i), .cnt_rdata_o(cnt_rdata_o),
      .ovf_clr_i(ovf_clr_i), .ovf_o(ovf_o), .aux_we_i(aux_we_i),
      .aux_wdata_i(aux_wdata_i), .aux_rdata_o(aux_rdata_o)
   );

   typedef struct packed {
      logic [CNT_W-1:0] cnt;
      logic             ovf;
      logic             inval;
      logic [CFG_W-1:0] cfg;
      logic [AUX_W-1:0] aux;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_cmp = 0;
   int    n_bad = 0;

   // driver-side stimulus for the next cycle
   logic [OCC_W-1:0] d_evt = '0, d_sib = '0;
   logic [1:0]       d_priv = 2'd3;
   logic             d_cfg_we = 0, d_cnt_we = 0, d_clr = 0, d_aux_we = 0;
   efc_cfg_t         d_cfg = '0;
   logic [CNT_W-1:0] d_cnt_wd = '0;
   logic [AUX_W-1:0] d_aux_wd = '0;

   // reference model state
   efc_cfg_t         m_cfg = '0;
   logic [CNT_W-1:0] m_cnt = '0;
   logic             m_ovf = 0, m_hist = 0;
   logic [AUX_W-1:0] m_aux = '0;

   function automatic efc_cfg_t mk(input bit run, usr, krn, inv, edg, any, input int thr);
      efc_cfg_t c;
      c.run = run; c.usr_en = usr; c.krn_en = krn; c.inv = inv;
      c.edge_on = edg; c.any_thr = any; c.thr = 8'(thr);
      return c;
   endfunction

   task automatic step(input string tag);
      int  sum, inc;
      bit  cond, pok, carry;
      logic [CNT_W:0] ext;
      exp_t e;
      @(negedge clk);
      evt_cnt_i = d_evt; sib_cnt_i = d_sib; priv_i = d_priv;
      cfg_we_i = d_cfg_we; cfg_wdata_i = d_cfg;
      cnt_we_i = d_cnt_we; cnt_wdata_i = d_cnt_wd;
      ovf_clr_i = d_clr; aux_we_i = d_aux_we; aux_wdata_i = d_aux_wd;
      sum  = m_cfg.any_thr ? int'(d_evt) + int'(d_sib) : int'(d_evt);
      cond = (sum >= int'(m_cfg.thr)) ^ m_cfg.inv;
      pok  = (d_priv == 2'd0) ? m_cfg.krn_en : m_cfg.usr_en;
      if (m_cfg.thr == 0) inc = sum;
      else if (m_cfg.edge_on) inc = (cond && !m_hist) ? 1 : 0;
      else inc = cond ? 1 : 0;
      if (!pok) inc = 0;
      carry = 0;
      if (d_cnt_we) m_cnt = d_cnt_wd;
      else if (m_cfg.run) begin
         ext = {1'b0, m_cnt} + (CNT_W+1)'(inc);
         m_cnt = ext[CNT_W-1:0];
         carry = ext[CNT_W];
      end
      if (carry) m_ovf = 1;
      else if (d_clr) m_ovf = 0;
      m_hist = m_cfg.run ? cond : 1'b0;
      if (d_cfg_we) m_cfg = d_cfg;
      if (d_aux_we) m_aux = d_aux_wd;
      e.cnt = m_cnt; e.ovf = m_ovf; e.cfg = m_cfg; e.aux = m_aux;
      e.inval = m_cfg.edge_on && (m_cfg.thr == 0);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      d_cfg_we = 0; d_cnt_we = 0; d_clr = 0; d_aux_we = 0;
   endtask

   task automatic set_cfg(input efc_cfg_t c, input string tag);
      d_cfg = c; d_cfg_we = 1; step(tag);
   endtask

   task automatic run_evt(input int n, input int ev, input int sb, input int pv, input string tag);
      for (int i = 0; i < n; i++) begin
         d_evt = OCC_W'(ev); d_sib = OCC_W'(sb); d_priv = 2'(pv); step(tag);
      end
   endtask

   // monitor: pops one expected item per edge and compares all ports
   initial begin
      exp_t  e;
      string t;
      forever begin
         @(posedge clk); #1;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front(); t = tag_q.pop_front();
            n_cmp++;
            if (cnt_rdata_o !== e.cnt || ovf_o !== e.ovf || cfg_invalid_o !== e.inval ||
                cfg_rdata_o !== e.cfg || aux_rdata_o !== e.aux) begin
               n_bad++;
               $display("FAIL %s: cnt=%0h ovf=%0b inv=%0b cfg=%0h aux=%0h expected cnt=%0h ovf=%0b inv=%0b cfg=%0h aux=%0h",
                        t, cnt_rdata_o, ovf_o, cfg_invalid_o, cfg_rdata_o, aux_rdata_o,
                        e.cnt, e.ovf, e.inval, e.cfg, e.aux);
            end
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      n_cmp++;
      if (cnt_rdata_o !== '0 || ovf_o !== 1'b0 || cfg_rdata_o !== '0 || aux_rdata_o !== '0 || cfg_invalid_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset: cnt=%0h ovf=%0b cfg=%0h aux=%0h expected all zero",
                  cnt_rdata_o, ovf_o, cfg_rdata_o, aux_rdata_o);
      end
      @(negedge clk); rst_n = 1'b1;

      // R1 / R2: raw add with threshold zero, invert ignored
      set_cfg(mk(1,1,1,0,0,0,0), "R1 cfg write");
      run_evt(3, 5, 0, 3, "R2 raw add");
      set_cfg(mk(1,1,1,1,0,0,0), "R2 invert ignored");
      run_evt(3, 7, 0, 1, "R2 invert ignored");
      // R3 threshold
      set_cfg(mk(1,1,1,0,0,0,4), "R3 thr");
      run_evt(1, 3, 0, 2, "R3 below"); run_evt(1, 4, 0, 2, "R3 equal");
      run_evt(1, 9, 0, 2, "R3 above"); run_evt(1, 2, 0, 2, "R3 below");
      // R4 invert
      set_cfg(mk(1,1,1,1,0,0,4), "R4 inv");
      run_evt(2, 1, 0, 3, "R4 below counts"); run_evt(2, 6, 0, 3, "R4 above no count");
      // R5 edge detect
      set_cfg(mk(1,1,1,0,1,0,1), "R5 edge");
      run_evt(2, 1, 0, 3, "R5 rise once"); run_evt(1, 0, 0, 3, "R5 low");
      run_evt(3, 2, 0, 3, "R5 rise again");
      set_cfg(mk(0,1,1,0,1,0,1), "R5 disable");
      run_evt(2, 1, 0, 3, "R5 disabled");
      set_cfg(mk(1,1,1,0,1,0,1), "R5 reenable");
      run_evt(3, 1, 0, 3, "R5 history cleared");
      // R6 invalid combo
      set_cfg(mk(1,1,1,0,1,0,0), "R6 invalid flag");
      run_evt(2, 3, 0, 3, "R6 raw add");
      // R7 / R8 privilege filtering
      set_cfg(mk(1,1,0,0,0,0,0), "R7 user only");
      run_evt(2, 2, 0, 0, "R7 ring0 blocked"); run_evt(2, 2, 0, 2, "R7 ring2 counts");
      set_cfg(mk(1,0,1,0,0,0,0), "R8 kernel only");
      run_evt(2, 3, 0, 1, "R8 ring1 blocked"); run_evt(2, 3, 0, 0, "R8 ring0 counts");
      // R9 any-thread
      set_cfg(mk(1,1,1,0,0,0,0), "R9 own only");
      run_evt(2, 2, 9, 3, "R9 sibling ignored");
      set_cfg(mk(1,1,1,0,0,1,6), "R9 any");
      run_evt(2, 3, 3, 3, "R9 combined meets thr"); run_evt(1, 3, 2, 3, "R9 combined below");
      // R10 wrap and sticky overflow
      set_cfg(mk(1,1,1,0,0,0,0), "R10 setup");
      d_evt = '0; d_cnt_we = 1; d_cnt_wd = {CNT_W{1'b1}} - 48'd2; step("R11 preset");
      run_evt(1, 5, 0, 3, "R10 wrap");
      run_evt(2, 1, 0, 3, "R10 sticky");
      d_evt = '0; d_clr = 1; step("R10 clear");
      // R11 write beats increment
      d_evt = 4'd7; d_cnt_we = 1; d_cnt_wd = 48'h1234; step("R11 write wins");
      // R12 aux register
      d_aux_we = 1; d_aux_wd = 64'hDEAD_BEEF_0123_4567; d_evt = '0; step("R12 aux write");
      run_evt(2, 0, 0, 3, "R12 aux holds");
      // R13 hold while stopped
      set_cfg(mk(0,1,1,0,0,0,0), "R13 stop");
      run_evt(3, 9, 4, 3, "R13 hold");

      // random phase against the model
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(0, 19) == 0) begin
            d_cfg = mk($urandom_range(0,7) != 0, $urandom_range(0,1), $urandom_range(0,1),
                       $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
                       ($urandom_range(0,3) == 0) ? 0 : int'($urandom_range(1, 20)));
            d_cfg_we = 1;
         end
         if ($urandom_range(0, 99) == 0) begin
            d_cnt_we = 1;
            d_cnt_wd = ($urandom_range(0,1) != 0) ? ({CNT_W{1'b1}} - 48'($urandom_range(0, 40)))
                                                  : 48'($urandom);
         end
         if ($urandom_range(0, 49) == 0) d_clr = 1;
         if ($urandom_range(0, 99) == 0) begin
            d_aux_we = 1; d_aux_wd = {32'($urandom), 32'($urandom)};
         end
         d_evt = OCC_W'($urandom); d_sib = OCC_W'($urandom); d_priv = 2'($urandom);
         step("MODEL random");
      end
      repeat (3) @(posedge clk);
      #2;
      finish_run();
   end
endmodule